// File: doc/BRIEF.md
# Egress Flow Status Tracker

This block produces, for every cell that passes through a cell processor, a single egress flow status flag that the cell marking logic consumes. Each cell arrives with a group of overhead bytes from the switch fabric, a connection number and a path indication (egress or ingress). Two configuration fields choose which overhead byte, and which bit inside that byte, carries the fabric's congestion hint for the connection.

On an egress cell, when the global status enable is set, the selected overhead bit is captured and stored as that connection's status bit in a one-bit-per-connection context store. On an ingress cell, the stored bit for the connection is recalled instead. A global "mark everything" control forces the flag on for every cell. A hint that the fabric gives on the egress side can then influence cells of the same connection that travel the opposite way. The store update is also presented on a status write port, one cycle after the cell.

Top module: `egress_flow_tracker`

## Requirements
- R1: After reset, `efs_valid`, `efs_flag` and `st_wr_en` are 0 and every connection's stored status bit is 0.
- R2: `efs_valid` is 1 exactly in the cycle after a cycle with `cell_start` high, and 0 otherwise.
- R3: The overhead status bit is `ovh_bytes[8*cfg_byte_sel + cfg_bit_sel]`. Byte 0 occupies bits 7:0.
- R4: When `cfg_mark_all` is 1, the flag for the cell is 1 regardless of path, overhead content, stored state or `cfg_fs_enable`.
- R5: For an egress cell (`cell_dir` = 1) with `cfg_fs_enable` = 1, the flag equals the selected overhead bit OR `cfg_mark_all`.
- R6: An egress cell with `cfg_fs_enable` = 1 stores the selected overhead bit as its connection's status bit. In the following cycle `st_wr_en` = 1, `st_wr_idx` = the cell's connection and `st_wr_data` = the bit.
- R7: With `cfg_fs_enable` = 0, a cell neither writes the store nor uses the overhead or stored bit: its flag equals `cfg_mark_all`.
- R8: For an ingress cell (`cell_dir` = 0) with `cfg_fs_enable` = 1, the flag equals the connection's stored status bit OR `cfg_mark_all`.
- R9: An ingress cell that starts in the cycle right after an egress cell of the same connection sees the bit that the egress cell wrote (write-first bypass).
- R10: Ingress cells never write the store: `st_wr_en` is 0 in the cycle after an ingress cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_start | input | 1 | One-cycle strobe marking a cell slot |
| cell_conn | input | IDX_W (8) | Connection number of the cell |
| cell_dir | input | 1 | 1 = egress path, 0 = ingress path |
| ovh_bytes | input | 8*OVH_BYTES (32) | Switch fabric overhead bytes, byte 0 in bits 7:0 |
| cfg_byte_sel | input | BSEL_W (2) | Overhead byte holding the status bit |
| cfg_bit_sel | input | 3 | Bit position inside the selected byte |
| cfg_fs_enable | input | 1 | Global enable for the overhead and stored status terms |
| cfg_mark_all | input | 1 | Forces the flag on for every cell |
| efs_valid | output | 1 | Flag valid strobe, one cycle after `cell_start` |
| efs_flag | output | 1 | Egress flow status for the cell |
| st_wr_en | output | 1 | Status store write strobe |
| st_wr_idx | output | IDX_W (8) | Connection being written |
| st_wr_data | output | 1 | Status bit being written |

## Verification
The store write of one egress cell and the store read of the next cell can fall in the same cycle, because the write is committed one cycle after its cell. The bench provokes this with directed back-to-back egress-then-ingress pairs on one connection, with both bit values. It also uses random traffic confined to a handful of connections with frequent zero-gap slots. Each ingress flag is judged against a bench model that applies every egress update at once, so a missed bypass shows up as a stale flag.

// File: rtl/efs_pkg.sv
package efs_pkg;

    localparam int DEF_CONNS     = 256;
    localparam int DEF_OVH_BYTES = 4;

    typedef enum logic {
        DIR_INGRESS = 1'b0,
        DIR_EGRESS  = 1'b1
    } cell_dir_e;

    typedef struct packed {
        logic fs_en;
        logic mark_all;
    } efs_cfg_t;

    // Combine global, overhead and stored terms into one status flag
    function automatic logic efs_combine(input efs_cfg_t cfg, input cell_dir_e dir,
                                         input logic ovh_bit, input logic stored);
        logic from_ovh;
        logic from_ctx;
        from_ovh = cfg.fs_en & (dir == DIR_EGRESS) & ovh_bit;
        from_ctx = cfg.fs_en & (dir == DIR_INGRESS) & stored;
        return cfg.mark_all | from_ovh | from_ctx;
    endfunction

endpackage

// File: rtl/efs_bit_pick.sv
module efs_bit_pick #(
    parameter int OVH_BYTES = efs_pkg::DEF_OVH_BYTES,
    localparam int BSEL_W   = (OVH_BYTES > 1) ? $clog2(OVH_BYTES) : 1
) (
    input  logic [8*OVH_BYTES-1:0] ovh,
    input  logic [BSEL_W-1:0]      byte_sel,
    input  logic [2:0]             bit_sel,
    output logic                   bit_o
);
    logic [7:0] lane [OVH_BYTES];
    logic [7:0] chosen;

    for (genvar g = 0; g < OVH_BYTES; g++) begin : g_lane
        assign lane[g] = ovh[8*g +: 8];
    end

    always_comb begin
        chosen = lane[byte_sel];
        bit_o  = chosen[bit_sel];
    end
endmodule

// File: rtl/efs_status_mem.sv
module efs_status_mem #(
    parameter int N_CONN = efs_pkg::DEF_CONNS,
    localparam int IDX_W = (N_CONN > 1) ? $clog2(N_CONN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_data
);
    logic [N_CONN-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (wr_en) begin
            status_q[wr_idx] <= wr_data;
        end
    end

    // Write-first: a pending write to the same connection wins
    always_comb begin
        if (wr_en && (wr_idx == rd_idx)) begin
            rd_data = wr_data;
        end else begin
            rd_data = status_q[rd_idx];
        end
    end
endmodule

// File: rtl/egress_flow_tracker.sv
module egress_flow_tracker
    import efs_pkg::*;
#(
    parameter int N_CONN    = DEF_CONNS,
    parameter int OVH_BYTES = DEF_OVH_BYTES,
    localparam int IDX_W    = (N_CONN > 1) ? $clog2(N_CONN) : 1,
    localparam int BSEL_W   = (OVH_BYTES > 1) ? $clog2(OVH_BYTES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cell_start,
    input  logic [IDX_W-1:0]       cell_conn,
    input  logic                   cell_dir,
    input  logic [8*OVH_BYTES-1:0] ovh_bytes,
    input  logic [BSEL_W-1:0]      cfg_byte_sel,
    input  logic [2:0]             cfg_bit_sel,
    input  logic                   cfg_fs_enable,
    input  logic                   cfg_mark_all,
    output logic                   efs_valid,
    output logic                   efs_flag,
    output logic                   st_wr_en,
    output logic [IDX_W-1:0]       st_wr_idx,
    output logic                   st_wr_data
);
    logic      ovh_bit;
    logic      stored_bit;
    efs_cfg_t  cfg;
    cell_dir_e dir;
    logic      capture;

    assign cfg.fs_en    = cfg_fs_enable;
    assign cfg.mark_all = cfg_mark_all;
    assign dir          = cell_dir_e'(cell_dir);
    assign capture      = cell_start && (dir == DIR_EGRESS) && cfg_fs_enable;

    efs_bit_pick #(.OVH_BYTES(OVH_BYTES)) u_pick (
        .ovh      (ovh_bytes),
        .byte_sel (cfg_byte_sel),
        .bit_sel  (cfg_bit_sel),
        .bit_o    (ovh_bit)
    );

    // Store commits the request registered for the previous cell
    efs_status_mem #(.N_CONN(N_CONN)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (st_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_data (st_wr_data),
        .rd_idx  (cell_conn),
        .rd_data (stored_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            efs_valid  <= 1'b0;
            efs_flag   <= 1'b0;
            st_wr_en   <= 1'b0;
            st_wr_idx  <= '0;
            st_wr_data <= 1'b0;
        end else begin
            efs_valid  <= cell_start;
            efs_flag   <= cell_start && efs_combine(cfg, dir, ovh_bit, stored_bit);
            st_wr_en   <= capture;
            st_wr_idx  <= cell_conn;
            st_wr_data <= ovh_bit;
        end
    end
endmodule

// File: rtl/efs_tracker_checker.sv
module efs_tracker_checker #(
    parameter int IDX_W  = 8,
    parameter int BSEL_W = 2,
    parameter int OVH_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cell_start,
    input logic [IDX_W-1:0]  cell_conn,
    input logic              cell_dir,
    input logic [OVH_W-1:0]  ovh_bytes,
    input logic [BSEL_W-1:0] cfg_byte_sel,
    input logic [2:0]        cfg_bit_sel,
    input logic              cfg_fs_enable,
    input logic              cfg_mark_all,
    input logic              efs_valid,
    input logic              efs_flag,
    input logic              st_wr_en,
    input logic [IDX_W-1:0]  st_wr_idx,
    input logic              st_wr_data
);
    p_valid_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        cell_start |=> efs_valid);

    p_valid_only_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        !cell_start |=> !efs_valid);

    p_mark_all_sets_flag_r4: assert property (@(posedge clk) disable iff (rst)
        cell_start && cfg_mark_all |=> efs_flag);

    p_disabled_flag_off_r7: assert property (@(posedge clk) disable iff (rst)
        cell_start && !cfg_mark_all && !cfg_fs_enable |=> !efs_flag);

    p_disabled_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        cell_start && !cfg_fs_enable |=> !st_wr_en);

    p_ingress_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        cell_start && !cell_dir |=> !st_wr_en);

    p_write_index_r6: assert property (@(posedge clk) disable iff (rst)
        cell_start && cell_dir && cfg_fs_enable |=> st_wr_en && (st_wr_idx == $past(cell_conn)));

    p_egress_flag_r5: assert property (@(posedge clk) disable iff (rst)
        cell_start && cell_dir && cfg_fs_enable && !cfg_mark_all |=> efs_flag == st_wr_data);
endmodule

bind egress_flow_tracker efs_tracker_checker #(
    .IDX_W  (IDX_W),
    .BSEL_W (BSEL_W),
    .OVH_W  (8*OVH_BYTES)
) u_chk (.*);

// File: tb/test_egress_flow_tracker.sv
module test_egress_flow_tracker;
    localparam int N_CONN = 256;
    localparam int OVH_B  = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        cell_start;
    logic [7:0]  cell_conn;
    logic        cell_dir;
    logic [31:0] ovh_bytes;
    logic [1:0]  cfg_byte_sel;
    logic [2:0]  cfg_bit_sel;
    logic        cfg_fs_enable;
    logic        cfg_mark_all;
    logic        efs_valid;
    logic        efs_flag;
    logic        st_wr_en;
    logic [7:0]  st_wr_idx;
    logic        st_wr_data;

    int tests = 0;
    int fails = 0;
    bit model_mem [N_CONN];

    always #10 clk = ~clk;

    egress_flow_tracker #(.N_CONN(N_CONN), .OVH_BYTES(OVH_B)) i_egress_flow_tracker (
        .clk(clk), .rst(rst), .cell_start(cell_start), .cell_conn(cell_conn),
        .cell_dir(cell_dir), .ovh_bytes(ovh_bytes), .cfg_byte_sel(cfg_byte_sel),
        .cfg_bit_sel(cfg_bit_sel), .cfg_fs_enable(cfg_fs_enable),
        .cfg_mark_all(cfg_mark_all), .efs_valid(efs_valid), .efs_flag(efs_flag),
        .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx), .st_wr_data(st_wr_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit pick_bit(input logic [31:0] ov, input int bs, input int ks);
        return ov[8*bs + ks];
    endfunction

    // Called at a falling edge; returns at the next falling edge after checking
    task automatic run_cell(input int conn, input bit eg, input logic [31:0] ov,
                            input int bs, input int ks, input bit en, input bit gm,
                            input string req);
        bit b;
        bit exp_flag;
        bit exp_wr;
        b        = pick_bit(ov, bs, ks);
        exp_flag = gm | (en & eg & b) | (en & !eg & model_mem[conn]);
        exp_wr   = en & eg;
        if (exp_wr) model_mem[conn] = b;
        cell_start    = 1'b1;
        cell_conn     = 8'(conn);
        cell_dir      = eg;
        ovh_bytes     = ov;
        cfg_byte_sel  = 2'(bs);
        cfg_bit_sel   = 3'(ks);
        cfg_fs_enable = en;
        cfg_mark_all  = gm;
        @(negedge clk);
        chk(efs_valid == 1'b1, "R2", "valid after start", int'(efs_valid), 1);
        chk(efs_flag == exp_flag, req, "flag", int'(efs_flag), int'(exp_flag));
        chk(st_wr_en == exp_wr, eg ? "R6" : "R10", "write strobe", int'(st_wr_en), int'(exp_wr));
        if (exp_wr) begin
            chk(st_wr_idx == 8'(conn), "R6", "write index", int'(st_wr_idx), conn);
            chk(st_wr_data == b, "R6", "write data", int'(st_wr_data), int'(b));
        end
        cell_start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            cell_start = 1'b0;
            @(negedge clk);
            chk(efs_valid == 1'b0, "R2", "valid idle", int'(efs_valid), 0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4471));
        for (int i = 0; i < N_CONN; i++) model_mem[i] = 1'b0;
        rst = 1'b1; cell_start = 1'b0; cell_conn = '0; cell_dir = 1'b0;
        ovh_bytes = '0; cfg_byte_sel = '0; cfg_bit_sel = '0;
        cfg_fs_enable = 1'b0; cfg_mark_all = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(efs_valid == 1'b0, "R1", "valid in reset", int'(efs_valid), 0);
        chk(efs_flag == 1'b0, "R1", "flag in reset", int'(efs_flag), 0);
        chk(st_wr_en == 1'b0, "R1", "write in reset", int'(st_wr_en), 0);
        rst = 1'b0;
        idle(2);
        // R1: stored bits start cleared
        run_cell(255, 1'b0, 32'hFFFF_FFFF, 3, 7, 1'b1, 1'b0, "R1");
        run_cell(0, 1'b0, 32'hFFFF_FFFF, 0, 0, 1'b1, 1'b0, "R1");
        // R3: every overhead position, as a one and as a zero in ones
        for (int bs = 0; bs < OVH_B; bs++) begin
            for (int ks = 0; ks < 8; ks++) begin
                run_cell(10, 1'b1, 32'h1 << (8*bs + ks), bs, ks, 1'b1, 1'b0, "R3");
                run_cell(10, 1'b1, ~(32'h1 << (8*bs + ks)), bs, ks, 1'b1, 1'b0, "R3");
            end
        end
        // R4: mark-all overrides everything
        run_cell(11, 1'b0, 32'h0, 0, 0, 1'b0, 1'b1, "R4");
        run_cell(11, 1'b1, 32'h0, 2, 5, 1'b1, 1'b1, "R4");
        // R7: disabled cells neither flag nor write
        run_cell(20, 1'b1, 32'hFFFF_FFFF, 1, 1, 1'b0, 1'b0, "R7");
        idle(1);
        run_cell(20, 1'b0, 32'h0, 0, 0, 1'b1, 1'b0, "R7");
        // R5 and R8: capture then recall after a gap
        run_cell(30, 1'b1, 32'h0000_4000, 1, 6, 1'b1, 1'b0, "R5");
        idle(2);
        run_cell(30, 1'b0, 32'h0, 0, 0, 1'b1, 1'b0, "R8");
        run_cell(30, 1'b0, 32'h0, 0, 0, 1'b0, 1'b0, "R7");
        // R9: back-to-back same connection, both values
        run_cell(40, 1'b1, 32'h8000_0000, 3, 7, 1'b1, 1'b0, "R5");
        run_cell(40, 1'b0, 32'h0, 0, 0, 1'b1, 1'b0, "R9");
        run_cell(40, 1'b1, 32'h7FFF_FFFF, 3, 7, 1'b1, 1'b0, "R5");
        run_cell(40, 1'b0, 32'hFFFF_FFFF, 0, 0, 1'b1, 1'b0, "R9");
        // R10: ingress cells leave the store alone
        run_cell(50, 1'b0, 32'hFFFF_FFFF, 0, 0, 1'b1, 1'b0, "R10");
        run_cell(50, 1'b0, 32'h0, 0, 0, 1'b1, 1'b0, "R10");
        // Random traffic on a few connections, frequent zero gaps
        for (int n = 0; n < 600; n++) begin
            int  conn;
            bit  eg;
            bit  en;
            bit  gm;
            conn = ($urandom % 6 == 0) ? 255 : int'($urandom % 6);
            eg   = 1'($urandom);
            en   = ($urandom % 5) != 0;
            gm   = ($urandom % 8) == 0;
            run_cell(conn, eg, $urandom, int'($urandom % 4), int'($urandom % 8), en, gm,
                     eg ? "R5" : "R9");
            if ($urandom % 4 == 0) idle(1);
        end
        idle(1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule